// File: doc/BRIEF.md
# Programmable Countdown Watchdog Timer

This block is a memory-mapped watchdog. It has a single-cycle register port: a write is taken on the clock edge on which the write strobe is high, and read data is a combinational function of the address. Software chooses a timeout code and an initial timeout code, then sets the enable bit. From then on a down-counter runs on the peripheral clock. Software must write a fixed restart key before the counter runs out.

Each 4-bit code N selects a period of 2^(BASE_EXP+N) clock cycles. With the default BASE_EXP of 16 the periods run from 2^16 to 2^31 cycles. The initial code sets the period for the load that happens when the block is enabled. The timeout code sets the period for every later reload.

When the counter runs out, the response-mode bit decides what happens. In mode 0 the block pulses the system-reset output. In mode 1 the block first raises an interrupt and reloads, and it pulses the reset only if a second timeout comes before a restart. Once the block is enabled, only a block reset can stop it.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0, the range register (offset 0x4) reads 0, `irq` and `sys_rst` are low, and the count register (offset 0x8) reads 2^BASE_EXP-1.
- R2: While disabled, the count register reads 2^(BASE_EXP+I)-1, where I is the initial code in range bits [7:4]. The value follows the latest range write from the cycle after that write.
- R3: A control write with bit 0 set enables the block and loads 2^(BASE_EXP+I)-1. From then on the count drops by one on every clock.
- R4: Once enabled, the block stays enabled: a control write with bit 0 clear leaves bit 0 reading 1. Bit 1 (response mode) can still be written.
- R5: A write of exactly 32'h76 to offset 0xC reloads the count with 2^(BASE_EXP+N)-1, where N is range bits [3:0]. A write of any other value there has no effect on the count.
- R6: In mode 0, when the count is at zero and no restart is written, the next clock raises `sys_rst` for RST_PULSE cycles. The count then holds at zero and restart writes are ignored.
- R7: In mode 1 the first timeout sets `irq` and reloads with period N. A restart clears `irq`. A second timeout with no restart in between pulses `sys_rst`.
- R8: A range write while running does not change the count. The new timeout code is used from the next reload.
- R9: Unused register bits read as zero. Offset 0xC and all unmapped offsets read zero.
- R10: `sys_rst` pulses at most once between block resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| wr_en | input | 1 | Write strobe, taken on the rising clock edge |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Timeout interrupt (mode 1) |
| sys_rst | output | 1 | System-reset pulse |

## Verification
If the counter state goes wrong, the count register shows it at once, because it reads the live value. A reload with the wrong code, a missed decrement or a reload that should not have happened shows up in the first read after the fault. A fault in the expiry or halt state shows on `irq` or `sys_rst` within one cycle of the counter reaching zero. It can also show later, as a pulse of the wrong length or a second pulse, or as a count that leaves zero after a restart write it should have ignored.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int          BASE_EXP  = 16,
  parameter int          RST_PULSE = 8,
  parameter logic [31:0] KEY       = 32'h0000_0076
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        sys_rst
);
  localparam int CNT_W = BASE_EXP + 16;
  localparam int PW    = $clog2(RST_PULSE + 1);
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_RNG  = 4'h4;
  localparam logic [3:0] A_CNT  = 4'h8;
  localparam logic [3:0] A_KICK = 4'hC;

  logic             en, resp, fired;
  logic [3:0]       top, init;
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pulse;

  function automatic logic [CNT_W-1:0] load_val(input logic [3:0] code);
    return (CNT_W'(1) << (BASE_EXP + 32'(code))) - CNT_W'(1);
  endfunction

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_rng  = wr_en && addr == A_RNG;
  wire kick    = wr_en && addr == A_KICK && wdata == KEY;
  wire [3:0] init_nxt = wr_rng ? wdata[7:4] : init;

  assign sys_rst = pulse != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      resp  <= 1'b0;
      fired <= 1'b0;
      irq   <= 1'b0;
      top   <= '0;
      init  <= '0;
      cnt   <= load_val(4'd0);
      pulse <= '0;
    end else begin
      if (pulse != '0) pulse <= pulse - PW'(1);
      if (wr_ctrl) begin
        resp <= wdata[1];
        if (wdata[0]) en <= 1'b1;
      end
      if (wr_rng) begin
        top  <= wdata[3:0];
        init <= wdata[7:4];
      end
      if (!en) begin
        cnt <= load_val(init_nxt);
      end else if (fired) begin
        cnt <= '0;
      end else if (kick) begin
        cnt <= load_val(top);
        irq <= 1'b0;
      end else if (cnt == '0) begin
        if (resp && !irq) begin
          irq <= 1'b1;
          cnt <= load_val(top);
        end else begin
          fired <= 1'b1;
          pulse <= PW'(RST_PULSE);
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {30'd0, resp, en};
      A_RNG:   rdata = {24'd0, init, top};
      A_CNT:   rdata = 32'(cnt);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int          CNT_W     = 32,
  parameter int          RST_PULSE = 8,
  parameter logic [31:0] KEY       = 32'h0000_0076
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [31:0]      wdata,
  input logic             en,
  input logic             fired,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             sys_rst
);
  wire kick_c = wr_en && addr == 4'hC && wdata == KEY;
  logic seen;
  int   hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      hi_cnt <= 0;
    end else begin
      if (sys_rst) seen <= 1'b1;
      hi_cnt <= sys_rst ? hi_cnt + 1 : 0;
    end
  end

  a_r4_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fired && cnt != '0 && !kick_c) |=> cnt == $past(cnt) - CNT_W'(1));
  a_r7_kick_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fired && kick_c) |=> !irq);
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fired |=> (fired && cnt == '0));
  a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> hi_cnt < RST_PULSE);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> !seen);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!irq && !sys_rst));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .en(en), .fired(fired), .cnt(cnt), .irq(irq), .sys_rst(sys_rst)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int BE = 4;
  localparam int RP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sys_rst;
  int checks = 0, fails = 0;
  bit done = 0;

  wdog_timer #(.BASE_EXP(BE), .RST_PULSE(RP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .sys_rst(sys_rst)
  );

  always #10 clk = ~clk;

  function automatic int unsigned ld(input int n);
    return (32'd1 << (BE + n)) - 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    void'($urandom(32'd20240611));
    tick();
    do_reset();
    // R1
    rd(4'h0, v); chk("R1 ctrl", v, 0);
    rd(4'h4, v); chk("R1 range", v, 0);
    rd(4'h8, v); chk("R1 count", v, ld(0));
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 sys_rst", {31'd0, sys_rst}, 0);
    // R2 and R9: random range writes while disabled
    for (int i = 0; i < 20; i++) begin
      logic [31:0] d;
      d = $urandom;
      wr(4'h4, d);
      rd(4'h8, v); chk("R2 idle count", v, ld(int'(d[7:4])));
      rd(4'h4, v); chk("R9 range bits", v, {24'd0, d[7:0]});
    end
    rd(4'hC, v); chk("R9 kick reads zero", v, 0);
    rd(4'h1, v); chk("R9 unmapped 1", v, 0);
    rd(4'hE, v); chk("R9 unmapped E", v, 0);
    wr(4'h0, 32'hFFFF_FFF0);
    rd(4'h0, v); chk("R9 ctrl upper bits", v, 0);
    wr(4'h0, 32'h0);
    // R3: enable with random initial codes
    for (int i = 0; i < 4; i++) begin
      int code, k;
      do_reset();
      code = int'($urandom % 4);
      wr(4'h4, 32'(code) << 4);
      wr(4'h0, 32'h1);
      rd(4'h8, v); chk("R3 enable load", v, ld(code));
      k = int'($urandom % 10);
      repeat (k) tick();
      rd(4'h8, v); chk("R3 countdown", v, ld(code) - k);
    end
    // R4
    do_reset();
    wr(4'h4, 32'h21);
    wr(4'h0, 32'h1);
    rd(4'h0, v); chk("R4 enabled", v, 1);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R4 clear ignored", v, 1);
    wr(4'h0, 32'h2);
    rd(4'h0, v); chk("R4 resp writable", v, 3);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R4 resp cleared en kept", v, 1);
    // R5
    wr(4'hC, 32'h76);
    rd(4'h8, c); chk("R5 key reload", c, ld(1));
    wr(4'hC, 32'h0000_0176);
    rd(4'h8, v); chk("R5 near-key ignored", v, c - 1); c = v;
    for (int i = 0; i < 10; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (d == 32'h76) d = 32'h77;
      wr(4'hC, d);
      rd(4'h8, v); chk("R5 wrong key ignored", v, c - 1); c = v;
    end
    // R8
    wr(4'hC, 32'h76);
    wr(4'h4, 32'h20);
    rd(4'h8, v); chk("R8 no immediate effect", v, ld(1) - 1);
    wr(4'hC, 32'h76);
    rd(4'h8, v); chk("R8 new code on reload", v, ld(0));
    // R6: mode 0 expiry
    repeat (ld(0)) tick();
    rd(4'h8, v); chk("R6 count at zero", v, 0);
    chk("R6 no early reset", {31'd0, sys_rst}, 0);
    for (int i = 0; i < RP; i++) begin
      tick();
      chk("R6 pulse high", {31'd0, sys_rst}, 1);
    end
    tick();
    chk("R6 pulse ends", {31'd0, sys_rst}, 0);
    wr(4'hC, 32'h76);
    rd(4'h8, v); chk("R6 kick ignored after expiry", v, 0);
    for (int i = 0; i < 40; i++) begin
      tick();
      if (sys_rst) chk("R10 second pulse", 1, 0);
    end
    chk("R10 no second pulse", {31'd0, sys_rst}, 0);
    // R7: interrupt mode
    do_reset();
    wr(4'h0, 32'h3);
    repeat (ld(0)) tick();
    chk("R7 irq low before timeout", {31'd0, irq}, 0);
    tick();
    chk("R7 irq set", {31'd0, irq}, 1);
    rd(4'h8, v); chk("R7 reload on first timeout", v, ld(0));
    chk("R7 no reset on first", {31'd0, sys_rst}, 0);
    wr(4'hC, 32'h76);
    chk("R7 kick clears irq", {31'd0, irq}, 0);
    repeat (ld(0) + 1) tick();
    chk("R7 irq again", {31'd0, irq}, 1);
    repeat (ld(0)) tick();
    chk("R7 no reset yet", {31'd0, sys_rst}, 0);
    tick();
    chk("R7 reset on second timeout", {31'd0, sys_rst}, 1);
    rd(4'h8, v); chk("R7 count holds zero", v, 0);
    repeat (20) tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule